// File: doc/BRIEF.md
# Boot ROM Remap Controller

This block decides, from the moment reset ends, whether the bottom of the address map is served by an internal boot ROM. The decision is made only when reset is active. If the boot-select pin asks for internal boot, a remap flag comes up set. While the flag is set, every address inside a window starting at zero is steered to the ROM. The steered address is the ROM base address plus the incoming address, and a ROM-select flag is raised. Addresses at or beyond the window size are never steered.

Software turns the remap off by writing to a clear register at byte offset 0x58 in the controller's register space. The write data does not matter and the register has no readable bits. Once the flag is off, only another reset can set it again. With the flag off, or after an external-boot reset, every address passes through unchanged and ROM-select stays low.

The address path is a valid/ready stream with no storage. A transfer happens in a cycle where both `addr_in_valid` and `addr_out_ready` are high. The downstream side gives back-pressure by holding `addr_out_ready` low. That value appears on `addr_in_ready` in the same cycle. `addr_out_valid` follows `addr_in_valid` in the same cycle. The steered address and ROM-select are valid in any cycle and depend only on the current address and the current remap flag. The register port and the boot-select pin are plain control signals.

Top module: `boot_remap_ctrl`

## Requirements
- R1: A reset taken with `boot_internal` high leaves the remap on, so after reset address 0 comes out as `ROM_BASE` with `rom_sel` high.
- R2: A reset taken with `boot_internal` low leaves the remap off, so after reset every address passes through with `rom_sel` low.
- R3: While the remap is on, an address below `ROM_BYTES` (default 16384) comes out as `ROM_BASE + addr` with `rom_sel` high, in the same cycle.
- R4: Even while the remap is on, an address at or above `ROM_BYTES` passes through unchanged with `rom_sel` low.
- R5: A write strobe with `reg_addr` equal to byte offset 0x58 turns the remap off from the next clock edge on, whatever `reg_wdata` holds.
- R6: Once the remap is off, it stays off until the next reset. Neither further register writes nor changes of `boot_internal` after reset can turn it back on.
- R7: A write strobe to any offset other than 0x58 leaves the remap state unchanged.
- R8: A read strobe is answered one cycle later with `reg_rvalid` high and `reg_rdata` all zeros, at any offset, including 0x58.
- R9: While the remap is off, `addr_out` equals `addr_in` and `rom_sel` is low, for every address.
- R10: The address stream is combinational: `addr_out_valid` equals `addr_in_valid` and `addr_in_ready` equals `addr_out_ready` in the same cycle.
- R11: An address presented in the same cycle as the clear write is still steered, because the remap turns off only at the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_internal | input | 1 | Boot select, sampled only while reset is active (1 = internal boot) |
| reg_addr | input | REG_AW (8) | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W (32) | Register write data (ignored) |
| reg_rd | input | 1 | Register read strobe |
| reg_rvalid | output | 1 | Read answer valid, one cycle after `reg_rd` |
| reg_rdata | output | DATA_W (32) | Read data, always zero |
| addr_in_valid | input | 1 | Upstream address valid |
| addr_in_ready | output | 1 | Upstream address accepted |
| addr_in | input | ADDR_W (32) | Incoming address |
| addr_out_valid | output | 1 | Downstream address valid |
| addr_out_ready | input | 1 | Downstream ready (back-pressure) |
| addr_out | output | ADDR_W (32) | Steered address |
| rom_sel | output | 1 | High when `addr_out` targets the boot ROM |

## Verification
The bench probes both sides of the window edge, `ROM_BYTES-1` and `ROM_BYTES`. An off-by-one window compare would send the first address past the ROM into it, or leave the last ROM word unmapped. It clears the remap with a zero data word and with an all-ones data word, and it writes to offsets next to 0x58. A decoder that looked at the data, or matched only some of the address bits, would miss a clear or clear by accident. After the clear, it toggles `boot_internal` and writes again to catch a flag that is set again. It also checks that a transfer in the cycle of the clear write is still steered, which catches a remap that is cut off too early.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  // Byte offset of the write-only clear register
  localparam int unsigned CLEAR_OFS = 'h58;

  // Register-side request decoded from the plain strobes
  typedef struct packed {
    logic clr_hit;
    logic rd_hit;
  } reg_req_t;

endpackage

// File: rtl/remap_flag.sv
module remap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_internal,
  input  logic clr_hit,
  output logic remap_on
);

  logic flag_q;

  // Boot mode is sampled only while reset is held; afterwards the flag can only fall
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= boot_internal;
    end else if (clr_hit) begin
      flag_q <= 1'b0;
    end
  end

  assign remap_on = flag_q;

endmodule

// File: rtl/remap_reg_if.sv
module remap_reg_if
  import boot_remap_pkg::*;
#(
  parameter int unsigned REG_AW = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output reg_req_t          req,
  output logic              reg_rvalid,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam logic [REG_AW-1:0] CLR_ADDR = REG_AW'(CLEAR_OFS);

  // Data of the clear write carries no meaning
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  assign req.clr_hit = reg_wr && (reg_addr == CLR_ADDR);
  assign req.rd_hit  = reg_rd;

  logic rvalid_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req.rd_hit;
    end
  end

  assign reg_rvalid = rvalid_q;
  assign reg_rdata  = '0;

endmodule

// File: rtl/remap_addr_steer.sv
module remap_addr_steer #(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       ROM_AW   = 14,
  parameter logic [ADDR_W-1:0] ROM_BASE = '0
) (
  input  logic              remap_on,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              rom_sel
);

  logic in_window;

  generate
    if (ROM_AW < ADDR_W) begin : g_window
      assign in_window = ~|addr_in[ADDR_W-1:ROM_AW];
    end else begin : g_full
      assign in_window = 1'b1;
    end
  endgenerate

  // Inside the window the incoming address is the ROM offset itself
  always_comb begin
    rom_sel  = remap_on && in_window;
    addr_out = rom_sel ? (ROM_BASE + addr_in) : addr_in;
  end

endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
  import boot_remap_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       REG_AW    = 8,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       ROM_BYTES = 16384,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_internal,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic              reg_rvalid,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              addr_in_valid,
  output logic              addr_in_ready,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              addr_out_valid,
  input  logic              addr_out_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic              rom_sel
);

  localparam int unsigned ROM_AW = $clog2(ROM_BYTES);

  reg_req_t req;
  logic     remap_on;

  remap_reg_if #(
    .REG_AW (REG_AW),
    .DATA_W (DATA_W)
  ) u_reg_if (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rd     (reg_rd),
    .req        (req),
    .reg_rvalid (reg_rvalid),
    .reg_rdata  (reg_rdata)
  );

  remap_flag u_flag (
    .clk           (clk),
    .rst_n         (rst_n),
    .boot_internal (boot_internal),
    .clr_hit       (req.clr_hit),
    .remap_on      (remap_on)
  );

  remap_addr_steer #(
    .ADDR_W   (ADDR_W),
    .ROM_AW   (ROM_AW),
    .ROM_BASE (ROM_BASE)
  ) u_steer (
    .remap_on (remap_on),
    .addr_in  (addr_in),
    .addr_out (addr_out),
    .rom_sel  (rom_sel)
  );

  // Stream passes straight through: no storage on the address path
  assign addr_out_valid = addr_in_valid;
  assign addr_in_ready  = addr_out_ready;

endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       REG_AW    = 8,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       ROM_BYTES = 16384,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 32'h8000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              reg_rvalid,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              rom_sel,
  input logic              remap_on
);

  localparam int unsigned       ROM_AW   = $clog2(ROM_BYTES);
  localparam logic [REG_AW-1:0] CLR_ADDR = REG_AW'(boot_remap_pkg::CLEAR_OFS);

  logic [ADDR_W-1:0] addr_hi;
  assign addr_hi = addr_in >> ROM_AW;

  assert_rom_steer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_on && addr_hi == '0) |-> (rom_sel && addr_out == ROM_BASE + addr_in));

  assert_window_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (addr_hi == '0));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == CLR_ADDR) |=> !remap_on);

  assert_sticky_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_on |=> !remap_on);

  assert_other_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_on && !(reg_wr && reg_addr == CLR_ADDR)) |=> remap_on);

  assert_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (reg_rvalid && reg_rdata == '0));

  assert_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_on |-> (!rom_sel && addr_out == addr_in));

endmodule

bind boot_remap_ctrl boot_remap_chk #(
  .ADDR_W    (ADDR_W),
  .REG_AW    (REG_AW),
  .DATA_W    (DATA_W),
  .ROM_BYTES (ROM_BYTES),
  .ROM_BASE  (ROM_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_rvalid (reg_rvalid),
  .reg_rdata  (reg_rdata),
  .addr_in    (addr_in),
  .addr_out   (addr_out),
  .rom_sel    (rom_sel),
  .remap_on   (remap_on)
);

// File: tb/boot_remap_ctrl_bench.sv
module boot_remap_ctrl_bench;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned REG_AW     = 8;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ROM_BYTES  = 16384;
  localparam logic [31:0] ROM_BASE   = 32'h8000_0000;
  localparam logic [7:0]  CLR        = 8'h58;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              boot_internal = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic              reg_rd = 1'b0;
  logic              reg_rvalid;
  logic [DATA_W-1:0] reg_rdata;
  logic              addr_in_valid = 1'b0;
  logic              addr_in_ready;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              addr_out_valid;
  logic              addr_out_ready = 1'b0;
  logic [ADDR_W-1:0] addr_out;
  logic              rom_sel;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_remap_ctrl #(
    .ADDR_W (ADDR_W), .REG_AW (REG_AW), .DATA_W (DATA_W),
    .ROM_BYTES (ROM_BYTES), .ROM_BASE (ROM_BASE)
  ) u_boot_remap_ctrl (
    .clk (clk), .rst_n (rst_n), .boot_internal (boot_internal),
    .reg_addr (reg_addr), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
    .reg_rd (reg_rd), .reg_rvalid (reg_rvalid), .reg_rdata (reg_rdata),
    .addr_in_valid (addr_in_valid), .addr_in_ready (addr_in_ready),
    .addr_in (addr_in), .addr_out_valid (addr_out_valid),
    .addr_out_ready (addr_out_ready), .addr_out (addr_out), .rom_sel (rom_sel)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Present an address and compare the steered result in the same cycle
  task automatic probe(input string req, input logic [31:0] a, input bit steered);
    logic [31:0] exp_addr;
    exp_addr = steered ? ROM_BASE + a : a;
    addr_in = a;
    #1;
    check(req, {rom_sel, addr_out}, {steered, exp_addr});
  endtask

  task automatic do_reset(input bit boot);
    @(negedge clk);
    rst_n = 1'b0;
    boot_internal = boot;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    boot_internal = ~boot;   // later changes must not matter
  endtask

  task automatic reg_write(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    reg_addr = ofs; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_reset_internal;
    do_reset(1'b1);
    probe("R1", 32'h0, 1'b1);
    check("R8 rvalid idle", {63'b0, reg_rvalid}, 64'd0);
  endtask

  task automatic t_window;
    probe("R3", 32'h0000_1234, 1'b1);
    probe("R3 last", ROM_BYTES - 1, 1'b1);
    probe("R4 edge", ROM_BYTES, 1'b0);
    probe("R4 high", 32'h2000_0010, 1'b0);
  endtask

  task automatic t_other_writes;
    reg_write(8'h54, 32'hFFFF_FFFF);
    reg_write(8'h5C, 32'hFFFF_FFFF);
    reg_write(8'hD8, 32'h0);
    probe("R7", 32'h10, 1'b1);
  endtask

  task automatic t_read_zero;
    int k;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      reg_addr = (i == 0) ? CLR : 8'h00;
      reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      #1;
      check("R8", {31'b0, reg_rvalid, reg_rdata}, {31'b0, 1'b1, 32'h0});
      k = i;
    end
  endtask

  task automatic t_clear_same_cycle(input logic [31:0] d);
    // Clear write and address in one cycle: steered now, off after the edge
    @(negedge clk);
    reg_addr = CLR; reg_wdata = d; reg_wr = 1'b1;
    probe("R11", 32'h40, 1'b1);
    @(negedge clk);
    reg_wr = 1'b0;
    probe("R5", 32'h40, 1'b0);
  endtask

  task automatic t_sticky;
    boot_internal = 1'b1;
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_write(CLR, 32'h1);
    boot_internal = 1'b0;
    @(negedge clk);
    boot_internal = 1'b1;
    @(negedge clk);
    probe("R6", 32'h0, 1'b0);
    probe("R9", ROM_BYTES - 4, 1'b0);
  endtask

  task automatic t_external;
    do_reset(1'b0);
    probe("R2", 32'h0, 1'b0);
    probe("R9 ext", 32'h0000_0100, 1'b0);
  endtask

  task automatic t_stream;
    @(negedge clk);
    addr_in_valid = 1'b1; addr_out_ready = 1'b0;
    #1;
    check("R10 bp", {62'b0, addr_out_valid, addr_in_ready}, {62'b0, 2'b10});
    addr_in_valid = 1'b0; addr_out_ready = 1'b1;
    #1;
    check("R10 rdy", {62'b0, addr_out_valid, addr_in_ready}, {62'b0, 2'b01});
  endtask

  initial begin
    t_reset_internal();
    t_window();
    t_other_writes();
    t_read_zero();
    t_stream();
    t_clear_same_cycle(32'h0);
    t_sticky();
    t_reset_internal();
    t_clear_same_cycle(32'hFFFF_FFFF);
    t_external();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule